// File: doc/BRIEF.md
# Scene Poll Scan Sequencer

This controller sits at the front of a sensing system that interrogates a set of small addressable targets one after another. A scan is started by software. For each target address, the controller waits for a timing tick and then launches one poll. A launch sends the address to an external transmitter with an enable of fixed length, pulses the start input of the external flight-time timers, and opens a measurement window. The window is as long as the slowest possible echo, so all four flight times are complete when it closes.

When the window closes, the controller raises a one-cycle request to the external coordinate solver. While the window is open it keeps the most recent attribute word reported by the target. Once the solver reports its result, the address, attribute word and both coordinates leave as one record on a valid/ready output. The next target is not launched until that record has been taken. After the record of the final address is accepted, a one-cycle completion pulse tells the host that the whole scene has been read. In manual mode the scan polls a single switch-selected address instead of sweeping.

Top module: `scan_poll_seq`

## Requirements
- R1: After reset, every output is low: `busy_o`, `tx_en_o`, `timer_start_o`, `window_o`, `compute_o`, `rec_valid_o` and `done_o`.
- R2: A high `start_i` while idle begins a sweep at address 0 and raises `busy_o` in the next cycle. `start_i` has no effect while `busy_o` is high.
- R3: A `tick_i` sampled while the sequencer waits for a tick launches a poll. In the cycle after that edge, `timer_start_o` is high for exactly one cycle. In that same cycle `tx_en_o` rises and then stays high for exactly TX_LEN cycles, with `tx_addr_o` carrying the poll address.
- R4: `window_o` rises together with `timer_start_o` and stays high for exactly WIN_LEN cycles. `compute_o` is a single-cycle pulse in the first cycle after `window_o` falls.
- R5: `tick_i` is ignored while a poll is in flight (window open, solving, or record pending) and while idle. No new `tx_en_o` burst or `timer_start_o` pulse follows it.
- R6: The record's 6-bit attribute field holds the value of `attr_i` at the last `attr_stb_i` sampled while `window_o` is high. Strobes outside the window are ignored. With no in-window strobe the field is 0.
- R7: `coord_done_i` is accepted only after `compute_o`. The record appears with `rec_valid_o` in the next cycle, carrying `coord_x_i` and `coord_y_i` as they were when `coord_done_i` was sampled. Its fields stay stable until `rec_ready_i` is seen.
- R8: In a sweep, the address of each following poll is one above the address of the record just accepted. A new poll cannot start before that acceptance.
- R9: `done_o` pulses high for one cycle, and `busy_o` falls, in the cycle after the record of address LAST_ADDR (or of the manual address) is accepted. There is no pulse after any other record.
- R10: If `manual_i` is high when a scan starts, the scan polls the address on `manual_addr_i` once and then completes as in R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a scan (ignored while busy) |
| manual_i | input | 1 | Manual single-address mode, sampled at start |
| manual_addr_i | input | 5 | Switch-selected address for manual mode |
| tick_i | input | 1 | Poll timing tick |
| attr_stb_i | input | 1 | Attribute word strobe from the receiver |
| attr_i | input | 6 | Attribute word |
| coord_done_i | input | 1 | Coordinate solver result ready |
| coord_x_i | input | 8 | Solved x coordinate |
| coord_y_i | input | 8 | Solved y coordinate |
| rec_ready_i | input | 1 | Host accepts the record |
| busy_o | output | 1 | A scan is in progress |
| tx_addr_o | output | 5 | Address being transmitted |
| tx_en_o | output | 1 | Transmitter enable, TX_LEN cycles |
| timer_start_o | output | 1 | One-cycle start for the flight-time timers |
| window_o | output | 1 | Measurement window, WIN_LEN cycles |
| compute_o | output | 1 | One-cycle coordinate computation request |
| rec_valid_o | output | 1 | Record valid |
| rec_addr_o | output | 5 | Record: polled address |
| rec_attr_o | output | 6 | Record: attribute word |
| rec_x_o | output | 8 | Record: x coordinate |
| rec_y_o | output | 8 | Record: y coordinate |
| done_o | output | 1 | One-cycle scan-complete pulse |

## Verification
The bench walks all 32 addresses twice, with a manual scan in between. This shows that a second start restarts at zero; a counter that was not reloaded would resume at 31 or at the manual address. Each poll counts the enable and window lengths cycle by cycle, so an off-by-one one-shot shows up as a burst one cycle too long or a late `compute_o`. Each poll also places attribute strobes inside and just outside the window, and on every fourth address leaves them out. A capture that ignored the window, or that kept the previous address's word, would then give the wrong attribute field. Stray ticks are issued while a poll is in flight and while a record is pending. A start is issued in mid-sweep. Extra `done_o` pulses are watched for after every record. A design that relaunched early, or completed the sweep on the wrong address, would break the address sequence or the completion timing.

// File: rtl/scan_poll_pkg.sv
package scan_poll_pkg;

  typedef enum logic [2:0] {
    SP_IDLE    = 3'd0,
    SP_ARM     = 3'd1,
    SP_MEASURE = 3'd2,
    SP_SOLVE   = 3'd3,
    SP_OFFER   = 3'd4
  } sp_state_e;

  // Address of the following poll in a sweep.
  function automatic logic [4:0] sp_next_addr(input logic [4:0] cur);
    return cur + 5'd1;
  endfunction

  // True when the record just offered is the final one of the scan.
  function automatic logic sp_is_final(input logic [4:0] cur,
                                       input logic       manual,
                                       input logic [4:0] last);
    return manual || (cur == last);
  endfunction

endpackage

// File: rtl/scan_poll_oneshot.sv
module scan_poll_oneshot #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic active,
  output logic final_cyc
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(LEN);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (fire)          cnt_q <= LOAD;
    else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
  end

  assign active    = (cnt_q != '0);
  assign final_cyc = (cnt_q == CW'(1));
endmodule

// File: rtl/scan_poll_addr.sv
module scan_poll_addr #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  output logic [AW-1:0] addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     addr <= '0;
    else if (load)  addr <= load_val;
    else if (step)  addr <= addr + AW'(1);
  end
endmodule

// File: rtl/scan_poll_record.sv
module scan_poll_record #(
  parameter int AW = 5,
  parameter int DW = 6,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_attr,
  input  logic          attr_take,
  input  logic [DW-1:0] attr_in,
  input  logic          capture,
  input  logic [AW-1:0] addr_in,
  input  logic [CW-1:0] x_in,
  input  logic [CW-1:0] y_in,
  output logic [AW-1:0] rec_addr,
  output logic [DW-1:0] rec_attr,
  output logic [CW-1:0] rec_x,
  output logic [CW-1:0] rec_y
);
  logic [DW-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hold_q <= '0;
    else if (clear_attr) hold_q <= '0;
    else if (attr_take)  hold_q <= attr_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_addr <= '0;
      rec_attr <= '0;
      rec_x    <= '0;
      rec_y    <= '0;
    end else if (capture) begin
      rec_addr <= addr_in;
      rec_attr <= hold_q;
      rec_x    <= x_in;
      rec_y    <= y_in;
    end
  end
endmodule

// File: rtl/scan_poll_seq.sv
module scan_poll_seq
  import scan_poll_pkg::*;
#(
  parameter int TX_LEN    = 4,
  parameter int WIN_LEN   = 16,
  parameter int LAST_ADDR = 31
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       manual_i,
  input  logic [4:0] manual_addr_i,
  input  logic       tick_i,
  input  logic       attr_stb_i,
  input  logic [5:0] attr_i,
  input  logic       coord_done_i,
  input  logic [7:0] coord_x_i,
  input  logic [7:0] coord_y_i,
  input  logic       rec_ready_i,
  output logic       busy_o,
  output logic [4:0] tx_addr_o,
  output logic       tx_en_o,
  output logic       timer_start_o,
  output logic       window_o,
  output logic       compute_o,
  output logic       rec_valid_o,
  output logic [4:0] rec_addr_o,
  output logic [5:0] rec_attr_o,
  output logic [7:0] rec_x_o,
  output logic [7:0] rec_y_o,
  output logic       done_o
);
  localparam int AW = 5;
  localparam int DW = 6;
  localparam int CW = 8;
  localparam logic [AW-1:0] LAST = AW'(LAST_ADDR);

  sp_state_e     st_q, st_d;
  logic          manual_q;
  logic [AW-1:0] cur_addr;
  logic          comp_q, tstart_q, done_q;

  // Named internal events
  logic ev_start, ev_launch, ev_win_end, ev_solved, ev_accept, ev_final;
  logic win_active, win_last, tx_active, tx_last;

  assign ev_start   = (st_q == SP_IDLE) && start_i;
  assign ev_launch  = (st_q == SP_ARM) && tick_i;
  assign ev_win_end = (st_q == SP_MEASURE) && win_last;
  assign ev_solved  = (st_q == SP_SOLVE) && coord_done_i;
  assign ev_accept  = (st_q == SP_OFFER) && rec_ready_i;
  assign ev_final   = sp_is_final(cur_addr, manual_q, LAST);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SP_IDLE:    if (ev_start)   st_d = SP_ARM;
      SP_ARM:     if (ev_launch)  st_d = SP_MEASURE;
      SP_MEASURE: if (ev_win_end) st_d = SP_SOLVE;
      SP_SOLVE:   if (ev_solved)  st_d = SP_OFFER;
      SP_OFFER:   if (ev_accept)  st_d = ev_final ? SP_IDLE : SP_ARM;
      default:                    st_d = SP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= SP_IDLE;
      manual_q <= 1'b0;
      comp_q   <= 1'b0;
      tstart_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      comp_q   <= ev_win_end;
      tstart_q <= ev_launch;
      done_q   <= ev_accept && ev_final;
      if (ev_start) manual_q <= manual_i;
    end
  end

  scan_poll_addr #(.AW(AW)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ev_start),
    .load_val (manual_i ? manual_addr_i : '0),
    .step     (ev_accept && !ev_final),
    .addr     (cur_addr)
  );

  scan_poll_oneshot #(.LEN(TX_LEN)) u_tx_shot (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (ev_launch),
    .active    (tx_active),
    .final_cyc (tx_last)
  );

  scan_poll_oneshot #(.LEN(WIN_LEN)) u_win_shot (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (ev_launch),
    .active    (win_active),
    .final_cyc (win_last)
  );

  scan_poll_record #(.AW(AW), .DW(DW), .CW(CW)) u_rec (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_attr (ev_launch),
    .attr_take  (attr_stb_i && win_active && (st_q == SP_MEASURE)),
    .attr_in    (attr_i),
    .capture    (ev_solved),
    .addr_in    (cur_addr),
    .x_in       (coord_x_i),
    .y_in       (coord_y_i),
    .rec_addr   (rec_addr_o),
    .rec_attr   (rec_attr_o),
    .rec_x      (rec_x_o),
    .rec_y      (rec_y_o)
  );

  assign busy_o        = (st_q != SP_IDLE);
  assign tx_addr_o     = cur_addr;
  assign tx_en_o       = tx_active;
  assign timer_start_o = tstart_q;
  assign window_o      = win_active;
  assign compute_o     = comp_q;
  assign rec_valid_o   = (st_q == SP_OFFER);
  assign done_o        = done_q;

  logic unused_tx_last;
  assign unused_tx_last = tx_last;
endmodule

// File: rtl/scan_poll_seq_chk.sv
module scan_poll_seq_chk #(
  parameter int TX_LEN  = 4,
  parameter int WIN_LEN = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_en_o,
  input logic       timer_start_o,
  input logic       window_o,
  input logic       compute_o,
  input logic       rec_valid_o,
  input logic       rec_ready_i,
  input logic [4:0] rec_addr_o,
  input logic [5:0] rec_attr_o,
  input logic [7:0] rec_x_o,
  input logic [7:0] rec_y_o,
  input logic       done_o,
  input logic       busy_o
);
  logic [15:0] tx_run, win_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_run  <= '0;
      win_run <= '0;
    end else begin
      tx_run  <= tx_en_o  ? tx_run + 16'd1  : 16'd0;
      win_run <= window_o ? win_run + 16'd1 : 16'd0;
    end
  end

  AST_TX_BURST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_en_o) |-> tx_run == 16'(TX_LEN)); // R3

  AST_TIMER_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    timer_start_o |=> !timer_start_o); // R3

  AST_LAUNCH_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    timer_start_o |-> (tx_en_o && window_o)); // R4

  AST_WINDOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(window_o) |-> win_run == 16'(WIN_LEN)); // R4

  AST_COMPUTE_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    compute_o |-> (!window_o && $past(window_o))); // R4

  AST_RECORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid_o && !rec_ready_i) |=> (rec_valid_o && $stable(rec_addr_o) &&
      $stable(rec_attr_o) && $stable(rec_x_o) && $stable(rec_y_o))); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(rec_valid_o && rec_ready_i))); // R9

  AST_NO_LAUNCH_WHILE_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid_o |-> !window_o); // R8
endmodule

bind scan_poll_seq scan_poll_seq_chk #(.TX_LEN(TX_LEN), .WIN_LEN(WIN_LEN)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tx_en_o       (tx_en_o),
  .timer_start_o (timer_start_o),
  .window_o      (window_o),
  .compute_o     (compute_o),
  .rec_valid_o   (rec_valid_o),
  .rec_ready_i   (rec_ready_i),
  .rec_addr_o    (rec_addr_o),
  .rec_attr_o    (rec_attr_o),
  .rec_x_o       (rec_x_o),
  .rec_y_o       (rec_y_o),
  .done_o        (done_o),
  .busy_o        (busy_o)
);

// File: tb/test_scan_poll_seq.sv
module test_scan_poll_seq;
  localparam int TXL = 4;
  localparam int WL  = 16;
  localparam int LA  = 31;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, manual_i = 0, tick_i = 0, attr_stb_i = 0;
  logic coord_done_i = 0, rec_ready_i = 0;
  logic [4:0] manual_addr_i = '0;
  logic [5:0] attr_i = '0;
  logic [7:0] coord_x_i = '0, coord_y_i = '0;
  logic busy_o, tx_en_o, timer_start_o, window_o, compute_o, rec_valid_o, done_o;
  logic [4:0] tx_addr_o, rec_addr_o;
  logic [5:0] rec_attr_o;
  logic [7:0] rec_x_o, rec_y_o;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  scan_poll_seq #(.TX_LEN(TXL), .WIN_LEN(WL), .LAST_ADDR(LA)) i_scan_poll_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .manual_i(manual_i),
    .manual_addr_i(manual_addr_i), .tick_i(tick_i), .attr_stb_i(attr_stb_i),
    .attr_i(attr_i), .coord_done_i(coord_done_i), .coord_x_i(coord_x_i),
    .coord_y_i(coord_y_i), .rec_ready_i(rec_ready_i), .busy_o(busy_o),
    .tx_addr_o(tx_addr_o), .tx_en_o(tx_en_o), .timer_start_o(timer_start_o),
    .window_o(window_o), .compute_o(compute_o), .rec_valid_o(rec_valid_o),
    .rec_addr_o(rec_addr_o), .rec_attr_o(rec_attr_o), .rec_x_o(rec_x_o),
    .rec_y_o(rec_y_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [5:0] attr_a(input int a); return 6'((a * 5 + 1) & 63); endfunction
  function automatic logic [5:0] attr_b(input int a); return 6'((a * 11 + 7) & 63); endfunction
  function automatic logic [7:0] xval(input int a);   return 8'((a * 7 + 3) & 255); endfunction
  function automatic logic [7:0] yval(input int a);   return 8'((250 - a * 3) & 255); endfunction

  // One complete poll; called at a negedge while the sequencer waits for a tick.
  task automatic poll_one(input int a, input bit fin, input int rdly);
    logic [5:0] exp_attr;
    exp_attr = (a % 4 == 0) ? 6'd0 : attr_b(a);
    tick_i = 1;
    @(negedge clk);
    tick_i = 0;
    for (int i = 0; i <= WL; i++) begin
      chk(tx_en_o == (i < TXL), "R3 tx_en", tx_en_o, i < TXL);
      if (i < TXL) chk(tx_addr_o == 5'(a), "R8 tx_addr", tx_addr_o, a);
      chk(timer_start_o == (i == 0), "R3 timer_start", timer_start_o, i == 0);
      chk(window_o == (i < WL), "R4 window", window_o, i < WL);
      chk(compute_o == (i == WL), "R4 compute", compute_o, i == WL);
      attr_stb_i = 0;
      if (a % 4 != 0 && i == 3) begin attr_stb_i = 1; attr_i = attr_a(a); end
      if (a % 4 != 0 && i == 5) begin attr_stb_i = 1; attr_i = attr_b(a); end
      if (i == WL) begin attr_stb_i = 1; attr_i = 6'h2A; end   // R6 outside window
      tick_i  = (i == 2);                                      // R5 stray tick
      start_i = (a == 3 && i == 1);                            // R2 start while busy
      @(negedge clk);
    end
    attr_stb_i = 0;
    chk(rec_valid_o == 0, "R7 no record before solve", rec_valid_o, 0);
    coord_done_i = 1; coord_x_i = xval(a); coord_y_i = yval(a);
    @(negedge clk);
    coord_done_i = 0; coord_x_i = 8'hEE; coord_y_i = 8'hDD;
    for (int k = 0; k < rdly; k++) begin
      chk(rec_valid_o == 1, "R7 valid", rec_valid_o, 1);
      chk(rec_addr_o == 5'(a), "R8 rec_addr", rec_addr_o, a);
      chk(rec_attr_o == exp_attr, "R6 rec_attr", rec_attr_o, exp_attr);
      chk(rec_x_o == xval(a), "R7 rec_x", rec_x_o, xval(a));
      chk(rec_y_o == yval(a), "R7 rec_y", rec_y_o, yval(a));
      chk(tx_en_o == 0, "R8 no launch before accept", tx_en_o, 0);
      tick_i = (k == 0);                                       // R5/R8 tick while pending
      @(negedge clk);
    end
    tick_i = 0;
    rec_ready_i = 1;
    @(negedge clk);
    rec_ready_i = 0;
    chk(rec_valid_o == 0, "R7 record taken", rec_valid_o, 0);
    chk(done_o == fin, "R9 done", done_o, fin);
    chk(busy_o == !fin, "R9 busy", busy_o, !fin);
    chk(tx_en_o == 0, "R5 tick ignored", tx_en_o, 0);
  endtask

  task automatic sweep();
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    chk(busy_o == 1, "R2 busy after start", busy_o, 1);
    for (int a = 0; a <= LA; a++) poll_one(a, a == LA, 1 + a % 3);
    @(negedge clk);
    chk(done_o == 0, "R9 single pulse", done_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy_o == 0, "R1 busy", busy_o, 0);
    chk(tx_en_o == 0 && timer_start_o == 0, "R1 tx/timer", tx_en_o, 0);
    chk(window_o == 0 && compute_o == 0, "R1 window/compute", window_o, 0);
    chk(rec_valid_o == 0 && done_o == 0, "R1 record/done", rec_valid_o, 0);
    tick_i = 1;                               // R5 tick while idle
    @(negedge clk);
    tick_i = 0;
    @(negedge clk);
    chk(tx_en_o == 0 && busy_o == 0, "R5 idle tick", tx_en_o, 0);
    sweep();
    manual_i = 1; manual_addr_i = 5'd13;      // R10 manual scan
    start_i = 1;
    @(negedge clk);
    start_i = 0; manual_i = 0; manual_addr_i = 5'd2;
    chk(busy_o == 1, "R10 busy", busy_o, 1);
    poll_one(13, 1, 2);
    sweep();                                  // R2 restart from address 0
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule